// File: doc/BRIEF.md
# Serial Write-Only Configuration Port

This block is a slave serial control port that loads a small bank of 8-bit configuration registers from an external controller. The controller drives a low-active select, a bit clock and a data line. All three pins are resynchronised into the system clock domain, and their edges are detected there. While the select is low, each rising edge of the bit clock samples one data bit, most significant bit first. Every eight bits form a byte.

The first byte of a frame names the device and the transfer direction. The second byte loads an internal pointer that holds a register index and an auto-increment flag. Each byte after that is written to the register the pointer selects. With the flag set, the pointer moves to the next register after every byte, so a controller can fill consecutive registers in one frame.

The register contents drive the rest of the chip through a flat bus. One register position carries a status byte from other logic, and the two low bits of register 1 carry two more externally driven bits. A sticky flag records that the serial select mode is in use. The system clock must run at least four times faster than the bit clock.

Top module: `spi_ctl_port`

## Requirements
- R1: After a synchronous reset, every writable register bit is 0, the pointer (`ptr_o`) reads 00h and `spi_mode_o` is 0.
- R2: A frame begins when the select goes low. Bits are sampled on rising bit-clock edges, MSB first, in groups of eight.
- R3: The first byte of a frame must equal 20h: device address 0010000 in bits 7..1 and a write indicator of 0 in bit 0. Any other value makes the block ignore every later byte until the select goes high.
- R4: The second byte loads the pointer. Bit 7 is the auto-increment flag, bits 2..0 are the register index, and bits 6..3 are stored as 0 whatever was sent.
- R5: Each following byte is written to the register at the pointer index. With bit 7 clear, the pointer does not change, so later bytes overwrite the same register.
- R6: With bit 7 set, the index advances by one after every data byte and wraps from 7 to 0. Writes to index 7, which holds no register, are dropped.
- R7: Bus slot 6 (bits 55..48) always shows `status_ro_i`, and bits 1..0 of slot 1 always show `ro_bits_i`. Serial writes to these bits change nothing.
- R8: A partial byte in progress when the select goes high is discarded. The next frame starts byte alignment afresh.
- R9: `spi_mode_o` is set by the first falling edge of the select after reset, and it stays set until the next reset.
- R10: A byte whose eighth bit is sampled before the select is released is committed, even when the select rises only one system clock after that final bit-clock edge.
- R11: Bit-clock edges while the select is high shift no bits and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Low-active select pin (asynchronous) |
| sck_i | input | 1 | Serial bit clock pin (asynchronous) |
| sdi_i | input | 1 | Serial data pin (asynchronous) |
| status_ro_i | input | 8 | Read-only byte shown at slot 6 |
| ro_bits_i | input | 2 | Read-only bits shown at slot 1, bits 1..0 |
| cfg_bank_o | output | 56 | Register slots 0..6, slot i at bits 8i+7..8i |
| ptr_o | output | 8 | Current pointer value |
| spi_mode_o | output | 1 | Sticky serial-select-mode flag |

## Verification
Two events can land in the same system clock cycle. The commit of a completed byte can coincide with the synchronised rise of the select, which also returns the frame decoder to its idle phase. The bench provokes this by raising the select pin exactly one system clock after the last bit-clock rise. It then judges that the byte is still written, that the next frame decodes from its first byte, and that the register bank matches the behavioural model on every settled cycle.

// File: rtl/spictl_pkg.sv
`timescale 1ns/1ps
package spictl_pkg;
    localparam int unsigned REG_W    = 8;
    localparam int unsigned NUM_REGS = 7;
    localparam int unsigned IDX_W    = 3;
    localparam int unsigned RO_REG   = 6;
    localparam int unsigned CTL_REG  = 1;
    localparam int unsigned RO_BITS  = 2;
    localparam logic [6:0]  DEV_ID   = 7'b0010000;
    localparam logic [7:0]  DEV_BYTE = {DEV_ID, 1'b0};

    typedef enum logic [1:0] {
        PH_DEV,
        PH_PTR,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic       incr;
        logic [3:0] zero;
        logic [2:0] idx;
    } ptr_t;

    typedef struct packed {
        logic act;
        logic rise_clk;
        logic data;
        logic fall_cs;
    } pinev_t;

    function automatic ptr_t make_ptr(input logic [7:0] b);
        ptr_t p;
        p.incr = b[7];
        p.zero = 4'b0000;
        p.idx  = b[2:0];
        return p;
    endfunction
endpackage

// File: rtl/cp_pin_sync.sv
`timescale 1ns/1ps
module cp_pin_sync
    import spictl_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   cs_n,
    input  logic   sck,
    input  logic   sdi,
    output pinev_t ev
);
    localparam int unsigned MSB = STAGES - 1;

    logic [STAGES-1:0] cs_s, sck_s, sdi_s;
    logic              cs_d, sck_d;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    cs_s <= '1; sck_s <= '0; sdi_s <= '0;
                end else begin
                    cs_s <= cs_n; sck_s <= sck; sdi_s <= sdi;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    cs_s <= '1; sck_s <= '0; sdi_s <= '0;
                end else begin
                    cs_s  <= {cs_s[STAGES-2:0], cs_n};
                    sck_s <= {sck_s[STAGES-2:0], sck};
                    sdi_s <= {sdi_s[STAGES-2:0], sdi};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d  <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= cs_s[MSB];
            sck_d <= sck_s[MSB];
        end
    end

    always_comb begin
        ev.act      = ~cs_s[MSB];
        ev.rise_clk = sck_s[MSB] & ~sck_d & ~cs_s[MSB];
        ev.data     = sdi_s[MSB];
        ev.fall_cs  = ~cs_s[MSB] & cs_d;
    end
endmodule

// File: rtl/cp_deframe.sv
`timescale 1ns/1ps
module cp_deframe
    import spictl_pkg::*;
#(
    parameter int unsigned W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  pinev_t       ev,
    output logic         byte_vld,
    output logic [W-1:0] byte_q
);
    localparam int unsigned CW = $clog2(W);

    logic [CW-1:0] cnt;
    logic [W-1:0]  sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            sh       <= '0;
            byte_vld <= 1'b0;
            byte_q   <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (!ev.act) begin
                cnt <= '0;
            end else if (ev.rise_clk) begin
                sh  <= {sh[W-2:0], ev.data};
                cnt <= cnt + 1'b1;
                if (cnt == CW'(W - 1)) begin
                    byte_vld <= 1'b1;
                    byte_q   <= {sh[W-2:0], ev.data};
                end
            end
        end
    end

    a_r2_byte_inside_frame: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> $past(ev.act));
    a_r8_fresh_alignment: assert property (@(posedge clk) disable iff (rst)
        $rose(ev.act) |-> (cnt == '0));
endmodule

// File: rtl/cp_regbank.sv
`timescale 1ns/1ps
module cp_regbank
    import spictl_pkg::*;
#(
    parameter int unsigned W = REG_W,
    parameter int unsigned N = NUM_REGS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_act,
    input  logic             byte_vld,
    input  logic [W-1:0]     byte_q,
    input  logic [W-1:0]     status_i,
    input  logic [RO_BITS-1:0] ro_bits_i,
    output logic [N*W-1:0]   bank_o,
    output logic [W-1:0]     ptr_o
);
    localparam int unsigned N_STORE = RO_REG;
    localparam logic [W-1:0] RO_MASK = W'((1 << RO_BITS) - 1);

    logic [W-1:0]         rf [N_STORE];
    logic [N_STORE*W-1:0] rf_flat;
    ptr_t                 ptr_q;
    phase_e               phase;
    logic                 wr_en;

    assign wr_en = byte_vld && (phase == PH_DATA);
    assign ptr_o = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_DEV;
            ptr_q <= '0;
        end else if (byte_vld) begin
            unique case (phase)
                PH_DEV:  phase <= (byte_q == DEV_BYTE) ? PH_PTR : PH_SKIP;
                PH_PTR: begin
                    ptr_q <= make_ptr(byte_q);
                    phase <= PH_DATA;
                end
                PH_DATA: if (ptr_q.incr) ptr_q.idx <= ptr_q.idx + 1'b1;
                PH_SKIP: phase <= PH_SKIP;
                default: phase <= PH_SKIP;
            endcase
        end else if (!cs_act) begin
            phase <= PH_DEV;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < int'(N_STORE); i++) begin
            if (rst) begin
                rf[i] <= '0;
            end else if (wr_en && ptr_q.idx == IDX_W'(i)) begin
                rf[i] <= (i == int'(CTL_REG)) ? (byte_q & ~RO_MASK) : byte_q;
            end
        end
    end

    generate
        for (genvar g = 0; g < int'(N); g++) begin : g_out
            if (g == int'(RO_REG)) begin : g_stat
                assign bank_o[g*W +: W] = status_i;
            end else if (g == int'(CTL_REG)) begin : g_ctl
                assign bank_o[g*W +: W] = {rf[g][W-1:RO_BITS], ro_bits_i};
            end else begin : g_rw
                assign bank_o[g*W +: W] = rf[g];
            end
        end
        for (genvar k = 0; k < int'(N_STORE); k++) begin : g_flat
            assign rf_flat[k*W +: W] = rf[k];
        end
    endgenerate

    a_r3_bad_device_skips: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && phase == PH_DEV && byte_q != DEV_BYTE) |=> (phase == PH_SKIP));
    a_r3_skip_writes_nothing: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |=> $stable(rf_flat));
    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        ptr_q.zero == 4'b0000);
    a_r5_fixed_pointer: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ptr_q.incr) |=> $stable(ptr_q));
    a_r6_index_wraps: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ptr_q.incr && ptr_q.idx == 3'd7) |=> (ptr_q.idx == 3'd0));
    a_r7_ro_bits_clear: assert property (@(posedge clk) disable iff (rst)
        (rf[CTL_REG] & RO_MASK) == '0);
endmodule

// File: rtl/spi_ctl_port.sv
`timescale 1ns/1ps
module spi_ctl_port
    import spictl_pkg::*;
#(
    parameter int unsigned W          = REG_W,
    parameter int unsigned N          = NUM_REGS,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n_i,
    input  logic               sck_i,
    input  logic               sdi_i,
    input  logic [W-1:0]       status_ro_i,
    input  logic [RO_BITS-1:0] ro_bits_i,
    output logic [N*W-1:0]     cfg_bank_o,
    output logic [W-1:0]       ptr_o,
    output logic               spi_mode_o
);
    pinev_t       ev;
    logic         byte_vld;
    logic [W-1:0] byte_q;
    logic         mode_q;

    cp_pin_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .cs_n(cs_n_i), .sck(sck_i), .sdi(sdi_i), .ev(ev)
    );

    cp_deframe #(.W(W)) u_deframe (
        .clk(clk), .rst(rst), .ev(ev), .byte_vld(byte_vld), .byte_q(byte_q)
    );

    cp_regbank #(.W(W), .N(N)) u_bank (
        .clk(clk), .rst(rst), .cs_act(ev.act), .byte_vld(byte_vld), .byte_q(byte_q),
        .status_i(status_ro_i), .ro_bits_i(ro_bits_i),
        .bank_o(cfg_bank_o), .ptr_o(ptr_o)
    );

    always_ff @(posedge clk) begin
        if (rst)             mode_q <= 1'b0;
        else if (ev.fall_cs) mode_q <= 1'b1;
    end
    assign spi_mode_o = mode_q;

    a_r9_mode_sticky: assert property (@(posedge clk) disable iff (rst)
        spi_mode_o |=> spi_mode_o);
    a_r9_mode_on_select: assert property (@(posedge clk) disable iff (rst)
        ev.fall_cs |=> spi_mode_o);
endmodule

// File: tb/sim_spi_ctl_port.sv
`timescale 1ns/1ps
module sim_spi_ctl_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic [7:0]  status_ro = 8'hA5;
    logic [1:0]  ro_bits = 2'b10;
    logic [55:0] bank;
    logic [7:0]  ptr;
    logic        mode;

    int nchk = 0, nfail = 0, hold = 0;
    bit started = 0;

    logic [7:0] m [6];
    logic [7:0] mptr = 8'h00;
    int mph = 0, mcnt = 0;
    logic [7:0] mbits = 8'h00;

    always #2.5 clk = ~clk;

    spi_ctl_port u0 (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .sck_i(sck), .sdi_i(sdi),
        .status_ro_i(status_ro), .ro_bits_i(ro_bits),
        .cfg_bank_o(bank), .ptr_o(ptr), .spi_mode_o(mode)
    );

    function automatic logic [7:0] dreg(int i);
        return bank[i*8 +: 8];
    endfunction

    function automatic logic [7:0] ereg(int i);
        if (i == 6) return status_ro;
        if (i == 1) return {m[1][7:2], ro_bits};
        return m[i];
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_byte(logic [7:0] b);
        if (mph == 0) mph = (b == 8'h20) ? 1 : 3;
        else if (mph == 1) begin
            mptr = {b[7], 4'b0000, b[2:0]};
            mph = 2;
        end else if (mph == 2) begin
            if (mptr[2:0] < 3'd6) m[mptr[2:0]] = (mptr[2:0] == 3'd1) ? (b & 8'hFC) : b;
            if (mptr[7]) mptr[2:0] = mptr[2:0] + 3'd1;
        end
    endtask

    task automatic model_rise(bit b);
        hold = 6;
        if (cs_n == 1'b0) begin
            mbits = {mbits[6:0], b};
            mcnt++;
            if (mcnt == 8) begin
                mcnt = 0;
                model_byte(mbits);
            end
        end
    endtask

    task automatic pin_bit(bit b);
        sdi = b; sck = 1'b0; tick(4);
        sck = 1'b1; model_rise(b); tick(4);
    endtask

    task automatic send_byte(logic [7:0] b);
        for (int i = 7; i >= 0; i--) pin_bit(b[i]);
    endtask

    task automatic sel_low();
        sck = 1'b0; cs_n = 1'b0; mph = 0; mcnt = 0; hold = 6; tick(4);
    endtask

    task automatic sel_high();
        sck = 1'b0; cs_n = 1'b1; mph = 0; mcnt = 0; hold = 6; tick(8);
    endtask

    task automatic frame(logic [7:0] dev, logic [7:0] p, logic [7:0] d[$]);
        sel_low();
        send_byte(dev);
        send_byte(p);
        foreach (d[i]) send_byte(d[i]);
        sel_high();
    endtask

    // continuous comparison against the model on settled cycles (R5 datapath)
    always @(posedge clk) begin
        #1;
        if (started && !rst) begin
            if (hold > 0) hold--;
            else begin
                bit ok = 1;
                for (int i = 0; i < 7; i++) if (dreg(i) !== ereg(i)) ok = 0;
                if (ptr !== mptr) ok = 0;
                chk(ok, "R5", "model compare bank", {bank}, {ereg(6), ereg(5), ereg(4),
                    ereg(3), ereg(2), ereg(1), ereg(0)});
            end
        end
    end

    initial begin
        #500000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] q[$];
        for (int i = 0; i < 6; i++) m[i] = 8'h00;
        tick(5);
        rst = 1'b0;
        tick(2);
        // R1 reset state
        chk(bank === {8'hA5, 32'h0, 8'h02, 8'h00}, "R1", "reset bank", bank, {8'hA5, 32'h0, 8'h02, 8'h00});
        chk(ptr === 8'h00, "R1", "reset pointer", ptr, 0);
        chk(mode === 1'b0, "R1", "reset mode flag", mode, 0);
        started = 1;

        // R9 mode set on first select fall; R2/R5 fixed pointer overwrite
        sel_low();
        chk(mode === 1'b1, "R9", "mode after select fall", mode, 1);
        send_byte(8'h20); send_byte(8'h02); send_byte(8'h5A);
        tick(6);
        chk(dreg(2) === 8'h5A, "R2", "first data byte", dreg(2), 8'h5A);
        send_byte(8'hC3);
        sel_high();
        chk(dreg(2) === 8'hC3, "R5", "overwrite same reg", dreg(2), 8'hC3);
        chk(ptr === 8'h02, "R5", "pointer fixed", ptr, 8'h02);

        // R6 auto-increment block write
        q = '{8'h11, 8'h22, 8'h33};
        frame(8'h20, 8'h83, q);
        chk({dreg(5), dreg(4), dreg(3)} === 24'h332211, "R6", "block write", {dreg(5), dreg(4), dreg(3)}, 24'h332211);
        chk(ptr === 8'h86, "R6", "pointer advanced", ptr, 8'h86);

        // R6 wrap and dropped index 7; R7 read-only slots
        q = '{8'h44, 8'h55, 8'h66, 8'h77, 8'h8B};
        frame(8'h20, 8'h85, q);
        chk(dreg(5) === 8'h44, "R6", "reg5 before wrap", dreg(5), 8'h44);
        chk(dreg(0) === 8'h77, "R6", "reg0 after wrap", dreg(0), 8'h77);
        chk(ptr === 8'h82, "R6", "pointer wrapped", ptr, 8'h82);
        chk(dreg(6) === 8'hA5, "R7", "status slot unwritten", dreg(6), 8'hA5);
        chk(dreg(1) === 8'h8A, "R7", "ro bits kept", dreg(1), 8'h8A);
        status_ro = 8'h3C; ro_bits = 2'b01;
        tick(2);
        chk(dreg(6) === 8'h3C, "R7", "status follows input", dreg(6), 8'h3C);
        chk(dreg(1) === 8'h89, "R7", "ro bits follow input", dreg(1), 8'h89);

        // R4 reserved pointer bits cleared
        sel_low();
        send_byte(8'h20); send_byte(8'hF9);
        tick(6);
        chk(ptr === 8'h81, "R4", "reserved bits zero", ptr, 8'h81);
        send_byte(8'hFF);
        sel_high();
        chk(dreg(1) === 8'hFD, "R4", "index from low bits", dreg(1), 8'hFD);

        // R3 wrong device byte / read indicator
        q = '{8'hEE};
        frame(8'h21, 8'h00, q);
        chk(dreg(0) === 8'h77, "R3", "read indicator ignored", dreg(0), 8'h77);
        frame(8'h30, 8'h00, q);
        chk(dreg(0) === 8'h77, "R3", "wrong address ignored", dreg(0), 8'h77);
        chk(ptr === 8'h82, "R3", "pointer untouched", ptr, 8'h82);

        // R8 partial byte discarded, next frame realigned
        sel_low();
        send_byte(8'h20); send_byte(8'h04);
        for (int i = 0; i < 5; i++) pin_bit(1'b1);
        sel_high();
        chk(dreg(4) === 8'h22, "R8", "partial byte dropped", dreg(4), 8'h22);
        q = '{8'h9C};
        frame(8'h20, 8'h04, q);
        chk(dreg(4) === 8'h9C, "R8", "realigned write", dreg(4), 8'h9C);

        // R11 bit clock toggling while deselected
        for (int i = 0; i < 16; i++) pin_bit(i[0]);
        tick(6);
        chk(dreg(4) === 8'h9C && dreg(0) === 8'h77, "R11", "idle clocks no write", {dreg(4), dreg(0)}, 16'h9C77);
        q = '{8'h3C};
        frame(8'h20, 8'h00, q);
        chk(dreg(0) === 8'h3C, "R11", "alignment after idle clocks", dreg(0), 8'h3C);

        // R10 select release one clock after final bit edge
        sel_low();
        send_byte(8'h20); send_byte(8'h02);
        for (int i = 7; i > 0; i--) pin_bit(1'(8'hA7 >> i));
        sdi = 1'b1; sck = 1'b0; tick(4);
        sck = 1'b1; model_rise(1'b1); tick(1);
        cs_n = 1'b1; mph = 0; mcnt = 0; tick(1); sck = 1'b0; tick(8);
        chk(dreg(2) === 8'hA7, "R10", "late-release byte committed", dreg(2), 8'hA7);
        q = '{8'h5D};
        frame(8'h20, 8'h03, q);
        chk(dreg(3) === 8'h5D, "R10", "next frame decodes", dreg(3), 8'h5D);
        chk(mode === 1'b1, "R9", "mode still held", mode, 1);

        tick(4);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule